// File: doc/BRIEF.md
# Half-Bridge SPI Control and Diagnosis Register

This block is the serial register of a three-channel half-bridge driver. An external controller selects it with an active-low chip select, clocks in a 16-bit control word least significant bit first, and in the same frame clocks out a 16-bit diagnosis word. The block samples the serial pins with a faster system clock through synchronizers and detects their edges in that domain.

A status snapshot taken when chip select falls is shifted out. The received word becomes the active control word when chip select rises, but only if the number of falling serial-clock edges in the frame is a non-zero multiple of 16. The active word is decoded into per-bridge high-side and low-side enables and two protection enables. A set bit 0 in a committed word gives a one-cycle request to clear latched faults. Because the shift register passes data straight through, two blocks can be chained on one select with a 32-bit frame. A power-on reset or the standby input clears the active word, which turns every switch off.

Top module: `hbridge_spi_regs`

## Requirements
- R1: Frames are 16 bits, least significant bit first: the first bit presented on `spi_mosi_i` ends up in bit 0 of `ctrl_word_o`, and the sixteenth in bit 15.
- R2: `spi_mosi_i` is sampled on the falling edge of `spi_sck_i`. `spi_miso_o` changes only on a rising edge of `spi_sck_i` or on the falling edge of chip select. After the (k+1)th rising edge it shows status bit k.
- R3: On the falling edge of `spi_cs_n_i`, `status_i` is copied into the shift register and `spi_miso_oe_o` goes high. `spi_miso_o` shows `status_i[0]` with no serial clock at all, and later changes of `status_i` during the frame have no effect on it.
- R4: On the rising edge of `spi_cs_n_i`, `spi_miso_oe_o` goes low.
- R5: On the rising edge of chip select, if the frame held a non-zero multiple of 16 falling clock edges, the last 16 bits shifted in become `ctrl_word_o`.
- R6: A frame with any other edge count, including zero, is discarded: `ctrl_word_o` keeps its previous value.
- R7: Bridge k (0 to 2) has its low-side enable `ls_on_o[k]` = control bit 1+2k and its high-side enable `hs_on_o[k]` = control bit 2+2k. `oc_shdn_en_o` = bit 13 and `ov_lock_en_o` = bit 15. A 1 means on.
- R8: A committed word with bit 0 set produces exactly one cycle of `status_clr_o` high. A discarded frame produces none.
- R9: The shift register acts as a pass-through. After 16 clock bits, `spi_miso_o` presents the bits received on `spi_mosi_i` 16 bits earlier. A 32-bit frame commits the last 16 bits received.
- R10: `rst_n` low or `standby_i` high clears `ctrl_word_o` (all switches off) and drives `spi_miso_oe_o` low. Frames sent while `standby_i` is high are ignored.
- R11: A last falling clock edge that arrives in the same system cycle as the chip-select rise is counted, and its bit is included in the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| standby_i | input | 1 | Standby request; holds the register cleared |
| spi_sck_i | input | 1 | Serial clock, idle low |
| spi_cs_n_i | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| spi_miso_oe_o | output | 1 | Output enable for the serial data out pad |
| status_i | input | 16 | Diagnosis word captured at frame start |
| ctrl_word_o | output | 16 | Active control word |
| status_clr_o | output | 1 | One-cycle request to clear latched faults |
| ls_on_o | output | 3 | Low-side switch enables, one per bridge |
| hs_on_o | output | 3 | High-side switch enables, one per bridge |
| oc_shdn_en_o | output | 1 | Overcurrent shutdown enable |
| ov_lock_en_o | output | 1 | Overvoltage lockout enable |

## Verification
The sixteenth falling serial-clock edge and the rising chip select can be detected in the same system cycle, and the commit must then take both the new bit and the new edge count into account. The bench provokes this by moving the serial clock low and chip select high at the same instant, so both go through identical synchronizer chains. It judges the result by comparing the committed control word with the full 16 bits that were sent, and by checking that a clear request follows when bit 0 is set.

// File: rtl/hbsr_pkg.sv
// Package: shared field positions of the half-bridge control word.
// Assumes the control word is at least 16 bits wide.
package hbsr_pkg;
    localparam int CLR_BIT    = 0;   // request to clear latched faults
    localparam int SW_BASE    = 1;   // first switch bit: low side of bridge 0
    localparam int OC_EN_BIT  = 13;  // overcurrent shutdown enable
    localparam int OV_EN_BIT  = 15;  // overvoltage lockout enable
    localparam int BITS_PER_BR = 2;  // low side, then high side
endpackage

// File: rtl/hbsr_sync.sv
// Module: multi-bit level synchronizer for asynchronous serial pins.
// Each bit goes through its own chain of STAGES flops. Assumes STAGES >= 2
// and that each input is a slow, independent level.
module hbsr_sync #(
    parameter int                 STAGES    = 2,
    parameter int                 WIDTH     = 3,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] level_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        // Shift the pin level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{RESET_VAL[g]}};
            else        chain_q <= {chain_q[STAGES-2:0], din_i[g]};
        end
        assign level_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/hbsr_shifter.sv
// Module: frame engine. Detects serial clock and select edges, loads the
// status snapshot, shifts data LSB first and counts falling edges.
// Assumes the inputs are already synchronized to clk and that the serial
// clock is idle low while select changes.
module hbsr_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s_i,
    input  logic               cs_n_s_i,
    input  logic               mosi_s_i,
    input  logic [FRAME_W-1:0] status_i,
    output logic               miso_o,
    output logic               miso_oe_o,
    output logic               frame_end_o,
    output logic               frame_ok_o,
    output logic [FRAME_W-1:0] frame_word_o
);
    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic               sck_d_q, cs_d_q;
    logic               sel_q, seen_q, miso_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shreg_q;

    logic               sck_rise, sck_fall, cs_fall, cs_rise, shift_now;
    logic [CNT_W-1:0]   cnt_nxt;
    logic               seen_nxt;
    logic [FRAME_W-1:0] word_nxt;

    // Remember last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d_q <= 1'b0;
            cs_d_q  <= 1'b1;
        end else begin
            sck_d_q <= sck_s_i;
            cs_d_q  <= cs_n_s_i;
        end
    end

    // Edge events and the frame state after a possible shift this cycle.
    always_comb begin
        sck_rise  = sck_s_i & ~sck_d_q;
        sck_fall  = ~sck_s_i & sck_d_q;
        cs_fall   = ~cs_n_s_i & cs_d_q;
        cs_rise   = cs_n_s_i & ~cs_d_q;
        shift_now = sel_q & sck_fall;
        word_nxt  = shift_now ? {mosi_s_i, shreg_q[FRAME_W-1:1]} : shreg_q;
        seen_nxt  = seen_q | shift_now;
        if (shift_now) cnt_nxt = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        else           cnt_nxt = cnt_q;
    end

    // Frame state: load on select fall, shift on clock edges, release on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            seen_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
            miso_q  <= 1'b0;
        end else if (cs_fall) begin
            sel_q   <= 1'b1;
            seen_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= status_i;
            miso_q  <= status_i[0];
        end else if (cs_rise) begin
            sel_q   <= 1'b0;
        end else begin
            shreg_q <= word_nxt;
            cnt_q   <= cnt_nxt;
            seen_q  <= seen_nxt;
            if (sel_q && sck_rise) miso_q <= shreg_q[0];
        end
    end

    assign miso_o       = miso_q;
    assign miso_oe_o    = sel_q;
    assign frame_end_o  = sel_q & cs_rise;
    assign frame_ok_o   = seen_nxt & (cnt_nxt == '0);
    assign frame_word_o = word_nxt;

    // R3
    snapshot_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (miso_oe_o && miso_o == $past(status_i[0])));
    // R2
    sample_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_now && !cs_rise) |=> shreg_q[FRAME_W-1] == $past(mosi_s_i));
    // R2
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sel_q && sck_rise) && !cs_fall) |=> $stable(miso_o));
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> !miso_oe_o);
endmodule

// File: rtl/hbsr_ctrl_latch.sv
// Module: active control word. Commits a completed frame and decodes the
// word into per-bridge switch enables and protection enables.
// Assumes commit requests come from hbsr_shifter and the field positions
// from hbsr_pkg.
module hbsr_ctrl_latch
    import hbsr_pkg::*;
#(
    parameter int FRAME_W     = 16,
    parameter int NUM_BRIDGES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_end_i,
    input  logic                   frame_ok_i,
    input  logic [FRAME_W-1:0]     frame_word_i,
    output logic [FRAME_W-1:0]     ctrl_word_o,
    output logic                   status_clr_o,
    output logic [NUM_BRIDGES-1:0] ls_on_o,
    output logic [NUM_BRIDGES-1:0] hs_on_o,
    output logic                   oc_shdn_en_o,
    output logic                   ov_lock_en_o
);
    logic [FRAME_W-1:0] ctrl_q;
    logic               clr_q;
    logic               commit;

    assign commit = frame_end_i & frame_ok_i;

    // Hold the active word; replace it only on a well-formed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (commit) ctrl_q <= frame_word_i;
    end

    // Single-cycle fault clear request for committed words with bit 0 set.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= commit & frame_word_i[CLR_BIT];
    end

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        assign ls_on_o[b] = ctrl_q[SW_BASE + BITS_PER_BR*b];
        assign hs_on_o[b] = ctrl_q[SW_BASE + BITS_PER_BR*b + 1];
    end

    assign ctrl_word_o  = ctrl_q;
    assign status_clr_o = clr_q;
    assign oc_shdn_en_o = ctrl_q[OC_EN_BIT];
    assign ov_lock_en_o = ctrl_q[OV_EN_BIT];

    // R6
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctrl_word_o));
    // R8
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr_o |=> !status_clr_o);
endmodule

// File: rtl/hbridge_spi_regs.sv
// Module: top of the half-bridge serial control and diagnosis register.
// Synchronizes the serial pins, runs the frame engine and holds the active
// control word. Assumes the system clock runs at least eight times faster
// than the serial clock. standby_i acts as a synchronous clear.
module hbridge_spi_regs #(
    parameter int FRAME_W     = 16,
    parameter int NUM_BRIDGES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   standby_i,
    input  logic                   spi_sck_i,
    input  logic                   spi_cs_n_i,
    input  logic                   spi_mosi_i,
    output logic                   spi_miso_o,
    output logic                   spi_miso_oe_o,
    input  logic [FRAME_W-1:0]     status_i,
    output logic [FRAME_W-1:0]     ctrl_word_o,
    output logic                   status_clr_o,
    output logic [NUM_BRIDGES-1:0] ls_on_o,
    output logic [NUM_BRIDGES-1:0] hs_on_o,
    output logic                   oc_shdn_en_o,
    output logic                   ov_lock_en_o
);
    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

    logic               blk_rst_n;
    logic [PIN_N-1:0]   pins_s;
    logic               frame_end, frame_ok;
    logic [FRAME_W-1:0] frame_word;

    assign blk_rst_n = rst_n & ~standby_i;

    hbsr_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (PIN_N),
        .RESET_VAL (PIN_RST)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   ({spi_mosi_i, spi_cs_n_i, spi_sck_i}),
        .level_o (pins_s)
    );

    hbsr_shifter #(
        .FRAME_W (FRAME_W)
    ) shifter_i (
        .clk          (clk),
        .rst_n        (blk_rst_n),
        .sck_s_i      (pins_s[0]),
        .cs_n_s_i     (pins_s[1]),
        .mosi_s_i     (pins_s[2]),
        .status_i     (status_i),
        .miso_o       (spi_miso_o),
        .miso_oe_o    (spi_miso_oe_o),
        .frame_end_o  (frame_end),
        .frame_ok_o   (frame_ok),
        .frame_word_o (frame_word)
    );

    hbsr_ctrl_latch #(
        .FRAME_W     (FRAME_W),
        .NUM_BRIDGES (NUM_BRIDGES)
    ) latch_i (
        .clk          (clk),
        .rst_n        (blk_rst_n),
        .frame_end_i  (frame_end),
        .frame_ok_i   (frame_ok),
        .frame_word_i (frame_word),
        .ctrl_word_o  (ctrl_word_o),
        .status_clr_o (status_clr_o),
        .ls_on_o      (ls_on_o),
        .hs_on_o      (hs_on_o),
        .oc_shdn_en_o (oc_shdn_en_o),
        .ov_lock_en_o (ov_lock_en_o)
    );

    // R10
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (ctrl_word_o == '0 && !spi_miso_oe_o && !status_clr_o));
endmodule

// File: tb/hbridge_spi_regs_tb.sv
`timescale 1ns/1ps
module hbridge_spi_regs_tb_top;
    localparam int W  = 16;
    localparam int NB = 3;
    localparam int H  = 6;       // serial half period in system cycles
    localparam real CLK_NS = 8.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, clr;
    logic [W-1:0] status = '0;
    logic [W-1:0] ctrl;
    logic [NB-1:0] ls_on, hs_on;
    logic oc_en, ov_en;

    int checks = 0, fails = 0, clr_cnt = 0;
    logic [31:0] got;
    logic        oe_seen;

    always #(CLK_NS/2) clk = ~clk;

    hbridge_spi_regs dut_i (
        .clk(clk), .rst_n(rst_n), .standby_i(standby),
        .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
        .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .status_i(status),
        .ctrl_word_o(ctrl), .status_clr_o(clr), .ls_on_o(ls_on),
        .hs_on_o(hs_on), .oc_shdn_en_o(oc_en), .ov_lock_en_o(ov_en)
    );

    always @(posedge clk) if (clr === 1'b1) clr_cnt++;

    typedef struct packed {
        logic [31:0] data;
        logic [15:0] st;
        logic [5:0]  nb;
        logic [15:0] exp;
        logic        clr;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{32'h0000_8046, 16'hA5C3, 6'd16, 16'h8046, 1'b0},
        '{32'h0000_2028, 16'h0001, 6'd16, 16'h2028, 1'b0},
        '{32'h0000_FFFE, 16'h8000, 6'd15, 16'h2028, 1'b0},
        '{32'h0001_0055, 16'h7FFF, 6'd17, 16'h2028, 1'b0},
        '{32'h0000_002A, 16'h1234, 6'd16, 16'h002A, 1'b0},
        '{32'h0000_0001, 16'hFFFF, 6'd16, 16'h0001, 1'b1}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks the active word and its decoded fields (R7).
    task automatic check_ctrl(input logic [15:0] e, input string req);
        logic [NB-1:0] el, eh;
        for (int k = 0; k < NB; k++) begin
            el[k] = e[1 + 2*k];
            eh[k] = e[2 + 2*k];
        end
        check(ctrl === e, req, 32'(ctrl), 32'(e));
        check(ls_on === el && hs_on === eh, "R7 switch decode",
              {26'd0, hs_on, ls_on}, {26'd0, eh, el});
        check(oc_en === e[13] && ov_en === e[15], "R7 protection decode",
              {30'd0, ov_en, oc_en}, {30'd0, e[15], e[13]});
    endtask

    // One frame of n bits; last falling edge optionally coincides with select rise.
    task automatic run_frame(input logic [31:0] data, input logic [15:0] st,
                             input int n, input bit coinc);
        got = '0;
        status = st;
        sck = 1'b0;
        mosi = 1'b0;
        wait_cyc(H);
        cs_n = 1'b0;
        wait_cyc(H);
        oe_seen = miso_oe;
        for (int i = 0; i < n; i++) begin
            sck = 1'b1;
            mosi = data[i];
            wait_cyc(H);
            got[i] = miso;
            sck = 1'b0;
            if (i == n - 1 && coinc) cs_n = 1'b1;
            wait_cyc(H);
        end
        cs_n = 1'b1;
        wait_cyc(H + 2);
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        logic [31:0] em;
        wait_cyc(4);
        // R10: reset state
        check(miso_oe === 1'b0 && clr === 1'b0, "R10 reset outputs",
              {30'd0, miso_oe, clr}, 32'd0);
        check_ctrl(16'h0000, "R10 reset word");
        rst_n = 1'b1;
        wait_cyc(4);

        // Table of frames walked by one loop.
        for (int v = 0; v < 6; v++) begin
            c0 = clr_cnt;
            run_frame(VEC[v].data, VEC[v].st, int'(VEC[v].nb), 1'b0);
            check(oe_seen === 1'b1, "R3 output enabled", {31'd0, oe_seen}, 32'd1);
            em = '0;
            for (int i = 0; i < int'(VEC[v].nb); i++)
                em[i] = (i < 16) ? VEC[v].st[i] : VEC[v].data[i-16];
            check(got === em, (VEC[v].nb > 16) ? "R9 pass-through" : "R2 status out",
                  got, em);
            check_ctrl(VEC[v].exp, (VEC[v].nb == 16) ? "R5 commit" : "R6 discard");
            check((clr_cnt - c0) == int'(VEC[v].clr), "R8 clear pulse",
                  32'(clr_cnt - c0), 32'(VEC[v].clr));
            check(miso_oe === 1'b0, "R4 released", {31'd0, miso_oe}, 32'd0);
        end

        // R1: first bit lands in bit 0, last bit in bit 15.
        run_frame(32'h0000_8001, 16'h0000, 16, 1'b0);
        check(ctrl === 16'h8001, "R1 lsb first", 32'(ctrl), 32'h8001);

        // R3: bit 0 shown without clock; snapshot survives status change.
        status = 16'h0001;
        wait_cyc(H);
        cs_n = 1'b0;
        wait_cyc(H);
        status = 16'h0000;
        wait_cyc(H);
        check(miso_oe === 1'b1 && miso === 1'b1, "R3 bit0 without clock",
              {30'd0, miso_oe, miso}, 32'd3);
        cs_n = 1'b1;
        wait_cyc(H + 2);
        check(miso_oe === 1'b0, "R4 released after idle frame", {31'd0, miso_oe}, 32'd0);
        check(ctrl === 16'h8001, "R6 zero-edge frame discarded", 32'(ctrl), 32'h8001);
        status = 16'h0000;
        cs_n = 1'b0;
        wait_cyc(H);
        check(miso === 1'b0, "R3 new snapshot", {31'd0, miso}, 32'd0);
        cs_n = 1'b1;
        wait_cyc(H + 2);

        // R9: 32-bit chained frame keeps the last 16 bits.
        c0 = clr_cnt;
        run_frame(32'h4025_1356, 16'hC3A5, 32, 1'b0);
        em = {16'h1356, 16'hC3A5};
        check(got === em, "R9 chain output", got, em);
        check_ctrl(16'h4025, "R9 chain commit");
        check((clr_cnt - c0) == 1, "R8 chain clear pulse", 32'(clr_cnt - c0), 32'd1);

        // R11: last falling edge coincident with select rise.
        run_frame(32'h0000_8012, 16'h0000, 16, 1'b1);
        check_ctrl(16'h8012, "R11 coincident edge");

        // R10: standby clears and blocks frames.
        standby = 1'b1;
        wait_cyc(3);
        check_ctrl(16'h0000, "R10 standby clear");
        run_frame(32'h0000_0040, 16'hFFFF, 16, 1'b0);
        check(oe_seen === 1'b0, "R10 no output in standby", {31'd0, oe_seen}, 32'd0);
        check_ctrl(16'h0000, "R10 standby frame ignored");
        standby = 1'b0;
        wait_cyc(4);
        run_frame(32'h0000_0040, 16'h0000, 16, 1'b0);
        check_ctrl(16'h0040, "R5 commit after standby");

        // R10: power reset clears the active word.
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check_ctrl(16'h0000, "R10 reset clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule